// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This block performs the processor-side work of taking an exception. A one-cycle start pulse carries the exception number. The block then takes a snapshot of the core context: the general registers R0 to R3 and R12, the link register, the return address, the status word, both stack pointers, the current mode, the stack-select bit and the vector table base. From that snapshot it works out where the context frame goes.

It writes the eight-word frame through a memory write port that uses a valid/ready handshake. It then fetches the handler address from the vector table through a read port with the same kind of handshake. Finally it presents the new stack pointers, the link-register return code, handler mode, the exception number and the new program counter, and it pulses `done`. The core copies these results into its architectural state.

A separate combinational path inspects branch targets. In handler mode, a target whose top nibble is all ones is reported as an exception return rather than a jump. That path is independent of the sequencer.

Top module: `exc_entry_seq`

## Requirements
- R1: The process stack pointer is selected when `stackSel` is 1 and `modeIn` is 0 (thread). In every other case the main stack pointer is selected. The pointer that is not selected appears unchanged on its output after the sequence.
- R2: The frame pointer is the selected pointer minus 0x20, with address bit 2 then cleared. This value becomes the new value of the selected pointer on `mspOut` or `pspOut`.
- R3: The stored status word equals `psrIn`, except that bit 9 is replaced by bit 2 of the selected pointer as it was before the decrement.
- R4: Exactly eight writes are issued, at frame pointer + 0x00, +0x04, up to +0x1C, in ascending address order. Their data, in that order, is R0, R1, R2, R3, R12, LR, return PC, status. Each write completes on a cycle where `wrValid` and `wrReady` are both high.
- R5: While `wrValid` is high and `wrReady` is low, `wrAddr` and `wrData` do not change.
- R6: `lrOut` becomes 0xFFFFFFF1 when the exception is entered from handler mode. From thread mode it becomes 0xFFFFFFF9 if the main stack was in use, or 0xFFFFFFFD if the process stack was in use.
- R7: After the sequence, `handlerOut` is 1 and `excNumOut` holds the exception number captured with the start pulse.
- R8: After the last write, one read is issued at `vtorIn` + 4 × exception number. `pcOut` takes the `rdData` value from the cycle in which `rdValid` and `rdReady` are both high.
- R9: `done` is high for exactly one cycle, the cycle after the read completes. `busy` is high from the cycle after start until that done cycle, inclusive.
- R10: A start pulse that arrives while `busy` is high is ignored. The running sequence keeps its captured exception number and still issues exactly eight writes.
- R11: `excReturn` is high in the same cycle that `brValid` is high, `modeIn` is 1 and `brTarget[31:28]` is 4'hF. In all other cases it is low. `excRetInfo` carries `brTarget[27:0]`.
- R12: After reset, `busy`, `done`, `wrValid`, `rdValid` and `handlerOut` are 0, and `lrOut` and `pcOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Starts an exception entry when the block is idle |
| excNum | input | EXC_W | Exception number to take |
| modeIn | input | 1 | Current mode, 1 = handler, 0 = thread |
| stackSel | input | 1 | Stack-select bit of the core |
| mspIn | input | 32 | Current main stack pointer |
| pspIn | input | 32 | Current process stack pointer |
| r0In | input | 32 | Register R0 |
| r1In | input | 32 | Register R1 |
| r2In | input | 32 | Register R2 |
| r3In | input | 32 | Register R3 |
| r12In | input | 32 | Register R12 |
| lrIn | input | 32 | Current link register |
| pcIn | input | 32 | Return address to stack |
| psrIn | input | 32 | Current status word |
| vtorIn | input | 32 | Vector table base |
| wrValid | output | 1 | Frame write request |
| wrReady | input | 1 | Memory accepts the write |
| wrAddr | output | 32 | Frame write address |
| wrData | output | 32 | Frame write data |
| rdValid | output | 1 | Vector read request |
| rdReady | input | 1 | Read completes; `rdData` is valid |
| rdAddr | output | 32 | Vector entry address |
| rdData | input | 32 | Vector entry contents |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mspOut | output | 32 | New main stack pointer |
| pspOut | output | 32 | New process stack pointer |
| lrOut | output | 32 | New link register (return code) |
| pcOut | output | 32 | Handler address |
| handlerOut | output | 1 | New mode, 1 = handler |
| excNumOut | output | EXC_W | New exception-number status field |
| brValid | input | 1 | Branch target presented |
| brTarget | input | 32 | Branch target address |
| excReturn | output | 1 | Branch is an exception return |
| excRetInfo | output | 28 | Low 28 bits of the return target |

## Verification
- **Start:** the start pulse is registered at one clock edge, and the first frame write appears on the port after that edge.
- **Writes:** each write holds on the port until the cycle in which ready is high. The next address appears one edge later.
- **Read:** the vector read is visible one edge after the last write is accepted.
- **Results:** `done` and every result are visible one edge after the read handshake. `done` falls at the following edge.
- **Exception return:** `excReturn` is combinational and is checked in the same cycle as its inputs.

The bench drives inputs and samples outputs on the falling edge. It stalls the ready inputs for a chosen number of cycles, so it knows the exact cycle in which each handshake completes. Every write, read and result is compared in that cycle, and the stability of a stalled request is checked on each stalled cycle.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int FRAME_WORDS   = 8;
  localparam int WORD_BYTES    = 4;
  localparam int FRAME_BYTES   = FRAME_WORDS * WORD_BYTES;
  localparam int IDX_W         = $clog2(FRAME_WORDS);
  localparam int PSR_ALIGN_BIT = 9;
  localparam int SP_ALIGN_BIT  = 2;

  localparam logic [31:0] RET_FROM_HANDLER = 32'hFFFF_FFF1;
  localparam logic [31:0] RET_THREAD_MAIN  = 32'hFFFF_FFF9;
  localparam logic [31:0] RET_THREAD_PROC  = 32'hFFFF_FFFD;
  localparam logic [3:0]  RET_PREFIX       = 4'hF;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STACK,
    ST_VECTOR,
    ST_DONE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // snapshot the context and compute the frame
    logic wordAccept;  // current frame word taken by memory
    logic commit;      // last word taken: update SP, LR, mode, number
    logic loadPc;      // vector read returned
  } seqCtrl_t;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startPulse,
  input  logic     wrReady,
  input  logic     rdReady,
  input  logic     lastWord,
  output seqCtrl_t strobes,
  output logic     wrValid,
  output logic     rdValid,
  output logic     busy,
  output logic     done
);
  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext          = state;
    strobes            = '0;
    strobes.capture    = (state == ST_IDLE) && startPulse;
    strobes.wordAccept = (state == ST_STACK) && wrReady;
    strobes.commit     = strobes.wordAccept && lastWord;
    strobes.loadPc     = (state == ST_VECTOR) && rdReady;
    unique case (state)
      ST_IDLE:   if (strobes.capture) stateNext = ST_STACK;
      ST_STACK:  if (strobes.commit)  stateNext = ST_VECTOR;
      ST_VECTOR: if (strobes.loadPc)  stateNext = ST_DONE;
      ST_DONE:   stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  assign wrValid = (state == ST_STACK);
  assign rdValid = (state == ST_VECTOR);
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);

  // R9: done lasts one cycle and the block is idle afterwards
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R9: done follows a completed read handshake
  assert_done_after_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(rdValid && rdReady));

  // R10: busy only starts from a start pulse
  assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startPulse));
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int EXC_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtrl_t         strobes,
  input  logic             wrValid,
  input  logic             wrReady,
  input  logic [EXC_W-1:0] excNum,
  input  logic             modeIn,
  input  logic             stackSel,
  input  logic [31:0]      mspIn,
  input  logic [31:0]      pspIn,
  input  logic [31:0]      r0In,
  input  logic [31:0]      r1In,
  input  logic [31:0]      r2In,
  input  logic [31:0]      r3In,
  input  logic [31:0]      r12In,
  input  logic [31:0]      lrIn,
  input  logic [31:0]      pcIn,
  input  logic [31:0]      psrIn,
  input  logic [31:0]      vtorIn,
  input  logic [31:0]      rdData,
  output logic [31:0]      wrAddr,
  output logic [31:0]      wrData,
  output logic [31:0]      rdAddr,
  output logic             lastWord,
  output logic [31:0]      mspOut,
  output logic [31:0]      pspOut,
  output logic [31:0]      lrOut,
  output logic [31:0]      pcOut,
  output logic             handlerOut,
  output logic [EXC_W-1:0] excNumOut
);
  localparam logic [31:0] FRAME_SIZE = 32'(FRAME_BYTES);
  localparam logic [31:0] ALIGN_MASK = ~(32'd1 << SP_ALIGN_BIT);

  // stack selection and frame placement from the live inputs
  logic        useProcNow;
  logic [31:0] selSpNow;
  logic [31:0] framePtrNow;
  logic [31:0] psrStackNow;

  always_comb begin
    useProcNow  = stackSel && !modeIn;
    selSpNow    = useProcNow ? pspIn : mspIn;
    framePtrNow = (selSpNow - FRAME_SIZE) & ALIGN_MASK;
    psrStackNow = psrIn;
    psrStackNow[PSR_ALIGN_BIT] = selSpNow[SP_ALIGN_BIT];
  end

  // captured context
  logic [31:0]      frameWord [FRAME_WORDS];
  logic [31:0]      framePtr;
  logic [31:0]      keepMsp;
  logic [31:0]      keepPsp;
  logic [31:0]      vtorQ;
  logic [EXC_W-1:0] numQ;
  logic             useProc;
  logic             fromHandler;
  logic [IDX_W-1:0] wordIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < FRAME_WORDS; i++) frameWord[i] <= '0;
      framePtr    <= '0;
      keepMsp     <= '0;
      keepPsp     <= '0;
      vtorQ       <= '0;
      numQ        <= '0;
      useProc     <= 1'b0;
      fromHandler <= 1'b0;
    end else if (strobes.capture) begin
      frameWord[0] <= r0In;
      frameWord[1] <= r1In;
      frameWord[2] <= r2In;
      frameWord[3] <= r3In;
      frameWord[4] <= r12In;
      frameWord[5] <= lrIn;
      frameWord[6] <= pcIn;
      frameWord[7] <= psrStackNow;
      framePtr     <= framePtrNow;
      keepMsp      <= mspIn;
      keepPsp      <= pspIn;
      vtorQ        <= vtorIn;
      numQ         <= excNum;
      useProc      <= useProcNow;
      fromHandler  <= modeIn;
    end
  end

  // frame word walker
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   wordIdx <= '0;
    else if (strobes.capture)    wordIdx <= '0;
    else if (strobes.wordAccept) wordIdx <= wordIdx + 1'b1;
  end

  assign lastWord = (wordIdx == IDX_W'(FRAME_WORDS - 1));
  assign wrAddr   = framePtr + {{(32-IDX_W-2){1'b0}}, wordIdx, 2'b00};
  assign wrData   = frameWord[wordIdx];
  assign rdAddr   = vtorQ + {{(32-EXC_W-2){1'b0}}, numQ, 2'b00};

  // return code selection
  logic [31:0] retCode;
  always_comb begin
    if (fromHandler)  retCode = RET_FROM_HANDLER;
    else if (useProc) retCode = RET_THREAD_PROC;
    else              retCode = RET_THREAD_MAIN;
  end

  // architectural results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mspOut     <= '0;
      pspOut     <= '0;
      lrOut      <= '0;
      handlerOut <= 1'b0;
      excNumOut  <= '0;
    end else if (strobes.commit) begin
      mspOut     <= useProc ? keepMsp : framePtr;
      pspOut     <= useProc ? framePtr : keepPsp;
      lrOut      <= retCode;
      handlerOut <= 1'b1;
      excNumOut  <= numQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pcOut <= '0;
    else if (strobes.loadPc) pcOut <= rdData;
  end

  // R5: a stalled write keeps address and data
  assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> ($stable(wrAddr) && $stable(wrData)));

  // R4: accepted writes step up by one word
  assert_wr_ascend_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady && !lastWord) |=> (wrAddr == $past(wrAddr) + 32'd4));

  // R2: first frame word lands on an 8-byte boundary
  assert_frame_align_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wordIdx == '0) |-> (wrAddr[2:0] == 3'b000));

  // R6: the link register holds a return code once the frame is written
  assert_lr_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> (handlerOut && lrOut[31:4] == 28'hFFF_FFFF));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int EXC_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [EXC_W-1:0] excNum,
  input  logic             modeIn,
  input  logic             stackSel,
  input  logic [31:0]      mspIn,
  input  logic [31:0]      pspIn,
  input  logic [31:0]      r0In,
  input  logic [31:0]      r1In,
  input  logic [31:0]      r2In,
  input  logic [31:0]      r3In,
  input  logic [31:0]      r12In,
  input  logic [31:0]      lrIn,
  input  logic [31:0]      pcIn,
  input  logic [31:0]      psrIn,
  input  logic [31:0]      vtorIn,
  output logic             wrValid,
  input  logic             wrReady,
  output logic [31:0]      wrAddr,
  output logic [31:0]      wrData,
  output logic             rdValid,
  input  logic             rdReady,
  output logic [31:0]      rdAddr,
  input  logic [31:0]      rdData,
  output logic             busy,
  output logic             done,
  output logic [31:0]      mspOut,
  output logic [31:0]      pspOut,
  output logic [31:0]      lrOut,
  output logic [31:0]      pcOut,
  output logic             handlerOut,
  output logic [EXC_W-1:0] excNumOut,
  input  logic             brValid,
  input  logic [31:0]      brTarget,
  output logic             excReturn,
  output logic [27:0]      excRetInfo
);
  seqCtrl_t strobes;
  logic     lastWord;

  exc_entry_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .wrReady(wrReady), .rdReady(rdReady), .lastWord(lastWord),
    .strobes(strobes), .wrValid(wrValid), .rdValid(rdValid),
    .busy(busy), .done(done)
  );

  exc_entry_dp #(.EXC_W(EXC_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrValid(wrValid), .wrReady(wrReady),
    .excNum(excNum), .modeIn(modeIn), .stackSel(stackSel),
    .mspIn(mspIn), .pspIn(pspIn),
    .r0In(r0In), .r1In(r1In), .r2In(r2In), .r3In(r3In), .r12In(r12In),
    .lrIn(lrIn), .pcIn(pcIn), .psrIn(psrIn), .vtorIn(vtorIn),
    .rdData(rdData), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .lastWord(lastWord), .mspOut(mspOut), .pspOut(pspOut),
    .lrOut(lrOut), .pcOut(pcOut), .handlerOut(handlerOut),
    .excNumOut(excNumOut)
  );

  // return-from-exception detection on branch targets
  assign excReturn  = brValid && modeIn && (brTarget[31:28] == RET_PREFIX);
  assign excRetInfo = brTarget[27:0];

  // R7: completion always reports handler mode
  assert_done_handler_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> handlerOut);

  // R8: no read is issued while the frame is still being written
  assert_read_after_stack_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !wrValid);
endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  localparam int EXC_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [EXC_W-1:0] excNum = '0;
  logic modeIn = 1'b0, stackSel = 1'b0;
  logic [31:0] mspIn = '0, pspIn = '0, r0In = '0, r1In = '0, r2In = '0, r3In = '0;
  logic [31:0] r12In = '0, lrIn = '0, pcIn = '0, psrIn = '0, vtorIn = '0;
  logic wrReady = 1'b0, rdReady = 1'b0;
  logic [31:0] rdData = '0;
  logic brValid = 1'b0;
  logic [31:0] brTarget = '0;
  logic wrValid, rdValid, busy, done, handlerOut, excReturn;
  logic [31:0] wrAddr, wrData, rdAddr, mspOut, pspOut, lrOut, pcOut;
  logic [EXC_W-1:0] excNumOut;
  logic [27:0] excRetInfo;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  exc_entry_seq #(.EXC_W(EXC_W)) i_exc_entry_seq (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .excNum(excNum),
    .modeIn(modeIn), .stackSel(stackSel), .mspIn(mspIn), .pspIn(pspIn),
    .r0In(r0In), .r1In(r1In), .r2In(r2In), .r3In(r3In), .r12In(r12In),
    .lrIn(lrIn), .pcIn(pcIn), .psrIn(psrIn), .vtorIn(vtorIn),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData),
    .rdValid(rdValid), .rdReady(rdReady), .rdAddr(rdAddr), .rdData(rdData),
    .busy(busy), .done(done), .mspOut(mspOut), .pspOut(pspOut),
    .lrOut(lrOut), .pcOut(pcOut), .handlerOut(handlerOut),
    .excNumOut(excNumOut), .brValid(brValid), .brTarget(brTarget),
    .excReturn(excReturn), .excRetInfo(excRetInfo)
  );

  typedef struct packed {
    logic        mode;
    logic        spsel;
    logic [31:0] msp;
    logic [31:0] psp;
    logic [31:0] psr;
    logic [5:0]  num;
    logic [1:0]  stall;
  } caseVec_t;

  localparam caseVec_t CASES [5] = '{
    '{1'b0, 1'b0, 32'h2000_1000, 32'h2000_8800, 32'h0100_0000, 6'd16, 2'd0},
    '{1'b0, 1'b1, 32'h2000_1200, 32'h2000_2004, 32'h6100_0010, 6'd17, 2'd1},
    '{1'b1, 1'b1, 32'h2000_300C, 32'h2000_9000, 32'h8100_0203, 6'd31, 2'd2},
    '{1'b1, 1'b0, 32'h2000_4000, 32'h2000_A000, 32'hF100_02FF, 6'd47, 2'd3},
    '{1'b0, 1'b1, 32'h2000_5008, 32'h2000_6018, 32'h2100_0000, 6'd20, 2'd1}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic runCase(input caseVec_t v, input int id, input bit inject);
    logic [31:0] oldSp, fp, psrExp, lrExp, pcExp, vecAddr;
    logic [31:0] words [8];
    bit useProc, injected;
    int k, stallLeft, guard;
    @(negedge clk);
    modeIn = v.mode; stackSel = v.spsel; mspIn = v.msp; pspIn = v.psp;
    psrIn = v.psr; excNum = v.num; vtorIn = 32'h1000_0000;
    r0In = 32'hA000_0000 + id; r1In = 32'hA100_0000 + id; r2In = 32'hA200_0000 + id;
    r3In = 32'hA300_0000 + id; r12In = 32'hAC00_0000 + id;
    lrIn = 32'h0800_1001 + id; pcIn = 32'h0800_2000 + 32'(id * 16);
    startPulse = 1'b1;
    // expectations from the requirements
    useProc = v.spsel && !v.mode;                          // R1
    oldSp = useProc ? v.psp : v.msp;
    fp = (oldSp - 32'h20) & ~32'h4;                         // R2
    psrExp = v.psr; psrExp[9] = oldSp[2];                   // R3
    lrExp = v.mode ? 32'hFFFF_FFF1 : (useProc ? 32'hFFFF_FFFD : 32'hFFFF_FFF9); // R6
    words[0] = r0In; words[1] = r1In; words[2] = r2In; words[3] = r3In;
    words[4] = r12In; words[5] = lrIn; words[6] = pcIn; words[7] = psrExp;
    vecAddr = 32'h1000_0000 + 32'(v.num) * 4;               // R8
    pcExp = 32'h0000_4001 + 32'(id) * 32'h100;
    @(negedge clk);
    startPulse = 1'b0;
    check(busy == 1'b1, "R9 busy after start", 32'(busy), 32'd1);
    k = 0; stallLeft = v.stall; guard = 0; injected = 1'b0;
    while (k < 8 && guard < 100) begin
      guard++;
      startPulse = 1'b0;
      excNum = v.num;
      check(wrValid == 1'b1, "R4 write request", 32'(wrValid), 32'd1);
      check(wrAddr == fp + 32'(k * 4), "R4/R2 write address", wrAddr, fp + 32'(k * 4));
      check(wrData == words[k], "R4/R3 write data", wrData, words[k]);
      if (inject && k == 3 && !injected) begin
        startPulse = 1'b1; excNum = 6'd9; injected = 1'b1;  // R10 stimulus
      end
      if (stallLeft > 0) begin
        wrReady = 1'b0; stallLeft--;                        // R5 stall
      end else begin
        wrReady = 1'b1; k++; stallLeft = v.stall;
      end
      @(negedge clk);
    end
    wrReady = 1'b0; startPulse = 1'b0; excNum = v.num;
    check(wrValid == 1'b0, "R4/R10 exactly eight writes", 32'(wrValid), 32'd0);
    stallLeft = v.stall;
    guard = 0;
    while (guard < 100) begin
      guard++;
      check(rdValid == 1'b1, "R8 read request", 32'(rdValid), 32'd1);
      check(rdAddr == vecAddr, "R8 vector address", rdAddr, vecAddr);
      check(done == 1'b0, "R9 no early done", 32'(done), 32'd0);
      if (stallLeft > 0) begin
        rdReady = 1'b0; stallLeft--;
        @(negedge clk);
      end else begin
        rdReady = 1'b1; rdData = pcExp;
        break;
      end
    end
    @(negedge clk);
    rdReady = 1'b0; rdData = 32'hDEAD_BEEF;
    check(done == 1'b1, "R9 done pulse", 32'(done), 32'd1);
    check(pcOut == pcExp, "R8 new PC", pcOut, pcExp);
    check(lrOut == lrExp, "R6 link return code", lrOut, lrExp);
    check(handlerOut == 1'b1, "R7 handler mode", 32'(handlerOut), 32'd1);
    check(excNumOut == v.num, "R7/R10 exception number", 32'(excNumOut), 32'(v.num));
    check(mspOut == (useProc ? v.msp : fp), "R1/R2 main SP", mspOut,
          useProc ? v.msp : fp);
    check(pspOut == (useProc ? fp : v.psp), "R1/R2 process SP", pspOut,
          useProc ? fp : v.psp);
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", 32'(done), 32'd0);
    check(busy == 1'b0, "R9 idle after done", 32'(busy), 32'd0);
    check(pcOut == pcExp, "R8 PC held", pcOut, pcExp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R12 busy in reset", 32'(busy), 32'd0);
    check(done == 1'b0, "R12 done in reset", 32'(done), 32'd0);
    check(wrValid == 1'b0 && rdValid == 1'b0, "R12 no requests", 32'({wrValid, rdValid}), 32'd0);
    check(handlerOut == 1'b0, "R12 thread mode", 32'(handlerOut), 32'd0);
    check(lrOut == 32'd0 && pcOut == 32'd0, "R12 LR/PC cleared", lrOut | pcOut, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R12 idle after reset", 32'(busy), 32'd0);

    // vector table walk: R1 to R9
    for (int i = 0; i < 5; i++) runCase(CASES[i], i, 1'b0);

    // R10: start during an active sequence is ignored
    runCase(CASES[1], 7, 1'b1);

    // R11: exception-return detection
    @(negedge clk);
    modeIn = 1'b1; brValid = 1'b1; brTarget = 32'hFFFF_FFF9;
    #1;
    check(excReturn == 1'b1, "R11 return in handler", 32'(excReturn), 32'd1);
    check(excRetInfo == 28'hFFF_FFF9, "R11 return info", 32'(excRetInfo), 32'h0FFF_FFF9);
    modeIn = 1'b0;
    #1;
    check(excReturn == 1'b0, "R11 no return in thread", 32'(excReturn), 32'd0);
    modeIn = 1'b1; brTarget = 32'hEFFF_FFFF;
    #1;
    check(excReturn == 1'b0, "R11 prefix mismatch", 32'(excReturn), 32'd0);
    brTarget = 32'hF000_0000; brValid = 1'b0;
    #1;
    check(excReturn == 1'b0, "R11 no branch valid", 32'(excReturn), 32'd0);
    brValid = 1'b1;
    #1;
    check(excReturn == 1'b1, "R11 minimal prefix", 32'(excReturn), 32'd1);
    brValid = 1'b0; modeIn = 1'b0;

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule